// File: doc/BRIEF.md
# Row Latch and Column Drive-Level Encoder

This block sits at the output stage of an LCD column driver. A row of pixel bits that was assembled upstream is captured in a row latch on the falling edge of the line strobe. For every column, the block then reports which of four panel drive levels the analog output stage should connect. Two levels are outer rails (top and bottom) and two are inner levels (upper-mid and lower-mid).

The level chosen for a column depends on three things: the latched pixel bit, the frame polarity signal that reverses the drive every frame, and an active-low display enable. When the display enable is low, every column goes to the top level. This is used to hold the panel quiet while the drive supplies settle. The polarity and enable inputs act combinationally, so the codes follow them without waiting for a clock edge. The latch changes only when a falling strobe edge is detected on the system clock.

Top module: `lcd_row_drive`

## Requirements
- R1: A synchronous active-high reset clears every latched pixel bit. After reset, with display enable high, every column code is 2'b01 when polarity is low and 2'b10 when polarity is high.
- R2: In the clock cycle where the sampled line strobe is low after having been high one clock earlier, the latch loads all row_data bits. The new codes are visible right after that clock edge.
- R3: Changes on row_data have no effect on the codes unless a falling strobe edge occurs. This holds while the strobe stays low, while it stays high, and on a rising strobe edge.
- R4: With display enable high, a lit column (latched bit 1) gives code 2'b11 (bottom level) when polarity is low and 2'b00 (top level) when polarity is high.
- R5: With display enable high, an unlit column (latched bit 0) gives code 2'b01 (upper-mid) when polarity is low and 2'b10 (lower-mid) when polarity is high.
- R6: While display enable is low, every column code is 2'b00, regardless of data and polarity. The override takes effect combinationally. The latch keeps loading during the override.
- R7: A change of polarity updates all codes combinationally, with no clock edge in between.
- R8: Column i takes its code from latched bit i and drives it on level_bus[2*i+1:2*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_strobe | input | 1 | Line latch strobe; its falling edge loads the row |
| row_data | input | NUM_COLS | Assembled row of pixel bits (1 = lit) |
| polarity | input | 1 | Frame polarity for drive reversal |
| display_en | input | 1 | Low forces every column to the top level |
| level_bus | output | 2*NUM_COLS | Packed two-bit drive-level code per column |

## Verification
A wrong latch bit shows up at the ports in the first check after the next falling strobe edge. It appears as one column pair holding the wrong code, and the bench tracks polarity to tell lit from unlit. A missing or spurious load shows up as the whole bus matching the previous row or an unexpected row. The bench detects this one cycle after the strobe edge, or at any point where the strobe is held still. Encoding or blanking faults are visible within one time step of a polarity or enable change, because those paths have no register.

// File: rtl/lcd_row_pkg.sv
package lcd_row_pkg;

    typedef enum logic [1:0] {
        LVL_TOP       = 2'b00,
        LVL_UPPER_MID = 2'b01,
        LVL_LOWER_MID = 2'b10,
        LVL_BOTTOM    = 2'b11
    } drive_lvl_t;

    typedef struct packed {
        logic polarity;
        logic display_en;
    } drive_ctl_t;

    function automatic drive_lvl_t pick_level(input logic pix, input drive_ctl_t ctl);
        drive_lvl_t lvl;
        if (!ctl.display_en)
            lvl = LVL_TOP;
        else if (pix)
            lvl = ctl.polarity ? LVL_TOP : LVL_BOTTOM;
        else
            lvl = ctl.polarity ? LVL_LOWER_MID : LVL_UPPER_MID;
        return lvl;
    endfunction

endpackage

// File: rtl/strobe_fall_det.sv
module strobe_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic fall
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst)
            strobe_q <= 1'b0;
        else
            strobe_q <= strobe;
    end

    assign fall = strobe_q & ~strobe;

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall); // R2

endmodule

// File: rtl/row_latch.sv
module row_latch #(
    parameter int NUM_COLS = 80
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [NUM_COLS-1:0] row_d,
    output logic [NUM_COLS-1:0] row_q
);
    always_ff @(posedge clk) begin
        if (rst)
            row_q <= '0;
        else if (load)
            row_q <= row_d;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> row_q == '0); // R1
    AST_LOAD_ROW: assert property (@(posedge clk) disable iff (rst)
        load |=> row_q == $past(row_d)); // R2
    AST_HOLD_ROW: assert property (@(posedge clk) disable iff (rst)
        (!load && !$past(rst)) |=> $stable(row_q)); // R3

endmodule

// File: rtl/column_level_enc.sv
module column_level_enc
    import lcd_row_pkg::*;
#(
    parameter int NUM_COLS = 80
) (
    input  logic [NUM_COLS-1:0]   pix,
    input  drive_ctl_t            ctl,
    output logic [2*NUM_COLS-1:0] lvl_bus
);
    localparam int CODE_W = $bits(drive_lvl_t);

    for (genvar i = 0; i < NUM_COLS; i++) begin : g_col
        drive_lvl_t lvl;
        always_comb lvl = pick_level(pix[i], ctl);
        assign lvl_bus[CODE_W*i +: CODE_W] = lvl;
    end

endmodule

// File: rtl/lcd_row_drive.sv
module lcd_row_drive
    import lcd_row_pkg::*;
#(
    parameter int NUM_COLS = 80
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  line_strobe,
    input  logic [NUM_COLS-1:0]   row_data,
    input  logic                  polarity,
    input  logic                  display_en,
    output logic [2*NUM_COLS-1:0] level_bus
);
    logic                load_row;
    logic [NUM_COLS-1:0] row_q;
    drive_ctl_t          ctl;

    assign ctl.polarity   = polarity;
    assign ctl.display_en = display_en;

    strobe_fall_det u_fall (
        .clk    (clk),
        .rst    (rst),
        .strobe (line_strobe),
        .fall   (load_row)
    );

    row_latch #(.NUM_COLS(NUM_COLS)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .load  (load_row),
        .row_d (row_data),
        .row_q (row_q)
    );

    column_level_enc #(.NUM_COLS(NUM_COLS)) u_enc (
        .pix     (row_q),
        .ctl     (ctl),
        .lvl_bus (level_bus)
    );

    AST_BLANK_TOP: assert property (@(posedge clk) disable iff (rst)
        !display_en |-> level_bus == '0); // R6

    for (genvar i = 0; i < NUM_COLS; i++) begin : g_chk
        AST_LIT_LEVEL: assert property (@(posedge clk) disable iff (rst)
            (display_en && row_q[i]) |-> level_bus[2*i +: 2] == (polarity ? 2'b00 : 2'b11)); // R4
        AST_UNLIT_LEVEL: assert property (@(posedge clk) disable iff (rst)
            (display_en && !row_q[i]) |-> level_bus[2*i +: 2] == (polarity ? 2'b10 : 2'b01)); // R5
    end

endmodule

// File: tb/lcd_row_drive_tb.sv
module lcd_row_drive_tb;
    localparam int NC = 80;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          line_strobe = 1'b0;
    logic [NC-1:0] row_data = '0;
    logic          polarity = 1'b0;
    logic          display_en = 1'b1;
    logic [2*NC-1:0] level_bus;

    int checks = 0;
    int errors = 0;
    logic [NC-1:0] exp_row = '0;

    always #4 clk = ~clk;

    lcd_row_drive #(.NUM_COLS(NC)) u_dut (
        .clk(clk), .rst(rst), .line_strobe(line_strobe), .row_data(row_data),
        .polarity(polarity), .display_en(display_en), .level_bus(level_bus)
    );

    function automatic logic [2*NC-1:0] model(input logic [NC-1:0] r, input logic p, input logic en);
        logic [2*NC-1:0] b;
        for (int i = 0; i < NC; i++) begin
            if (!en)       b[2*i +: 2] = 2'b00;
            else if (r[i]) b[2*i +: 2] = p ? 2'b00 : 2'b11;
            else           b[2*i +: 2] = p ? 2'b10 : 2'b01;
        end
        return b;
    endfunction

    task automatic check(input string req);
        logic [2*NC-1:0] e;
        e = model(exp_row, polarity, display_en);
        checks++;
        if (level_bus !== e) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, level_bus, e);
        end
    endtask

    task automatic load_row(input logic [NC-1:0] r);
        @(negedge clk); row_data = r; line_strobe = 1'b1;
        @(negedge clk); line_strobe = 1'b0;
        @(posedge clk); exp_row = r;
        @(negedge clk);
    endtask

    function automatic logic [NC-1:0] rnd_row();
        logic [95:0] t;
        t = {$urandom, $urandom, $urandom};
        return t[NC-1:0];
    endfunction

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(1234);
        row_data = rnd_row();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset pol0");
        polarity = 1'b1; #1;
        check("R1 reset pol1");

        load_row('1);
        polarity = 1'b0; #1; check("R4 lit pol0");
        polarity = 1'b1; #1; check("R4 lit pol1 R7");
        load_row('0);
        check("R5 unlit pol1");
        polarity = 1'b0; #1; check("R5 unlit pol0 R7");

        load_row({{(NC-1){1'b0}}, 1'b1});
        check("R8 column0");
        load_row({1'b1, {(NC-1){1'b0}}});
        check("R8 top column");

        load_row(rnd_row());
        row_data = rnd_row(); repeat (3) @(negedge clk);
        check("R3 strobe low");
        line_strobe = 1'b1; row_data = rnd_row(); repeat (3) @(negedge clk);
        check("R3 strobe high");
        row_data = rnd_row(); line_strobe = 1'b0;
        @(posedge clk); exp_row = row_data; @(negedge clk);
        check("R2 fall after long high");

        display_en = 1'b0; #1; check("R6 blank immediate");
        polarity = 1'b1; #1; check("R6 blank pol1");
        load_row(rnd_row());
        check("R6 blank during load");
        display_en = 1'b1; #1; check("R6 release shows loaded row");

        for (int k = 0; k < 40; k++) begin
            load_row(rnd_row());
            polarity = $urandom_range(0, 1);
            display_en = ($urandom_range(0, 3) != 0);
            #1; check("R2 R4 R5 R6 random");
        end

        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        exp_row = '0; display_en = 1'b1; polarity = 1'b0; #1;
        check("R1 reset after traffic");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule